// File: doc/BRIEF.md
# Multi-Round Wide Operand Reduction Adder

This block adds up ten 256-bit values and returns one 256-bit total. The values sit in ten operand registers. Software or a neighbouring block writes them one at a time, by index, while the block is idle. A start strobe then launches a reduction.

Five pipelined 256-bit adders run side by side. Adder k is fed the register pair (2k, 2k+1). The adders have a fixed latency of 22 cycles. Each round therefore waits a padded 25 cycles, and there is no valid handshake. At the end of a round, adder k's result is written into register k and registers 5 to 9 are cleared, so every round has the same shape. Five rounds are always run. After the last one the total sits in register 0, which drives the output, and a one-cycle done pulse is issued.

The controller has two named states. In IDLE it accepts loads and waits for start. The transition IDLE→RUN is taken on start. In RUN a cycle counter counts 0 to 24 and a round counter counts 0 to 4. The transition RUN→RUN is a write-back at cycle 24 of rounds 0 to 3. The transition RUN→IDLE is the write-back at cycle 24 of round 4, and it also raises done.

Top module: `wide_sum_reducer`

## Requirements
- R1: A synchronous active-high reset clears all operand registers, both counters and done, so after reset done is 0 and total is 0.
- R2: While idle, a load with ld_en=1 writes ld_data into the operand register numbered ld_idx (valid indices 0 to 9). A load with ld_idx from 10 to 15 changes nothing.
- R3: A load issued while a reduction runs has no effect. This includes a load sampled at the final write-back edge.
- R4: A start sampled while idle begins a reduction. Done rises at the 125th rising edge after the edge that accepted start (5 rounds × 25 cycles). This wait covers the 22-cycle adder latency.
- R5: Done is high for exactly one clock cycle per reduction.
- R6: Total equals the sum of the ten loaded operands modulo 2^256. Any carry out of bit 255 is dropped.
- R7: Start asserted while a reduction runs is ignored. The run is not restarted and its done timing is unchanged.
- R8: After done, total holds its value until register 0 is reloaded or a new run writes back. Registers 1 to 9 are zero after a run, so re-running without loads reproduces the same total.
- R9: A start asserted in the same cycle as the done pulse is accepted and begins a new reduction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a reduction (honoured only when idle) |
| ld_en | input | 1 | Operand write strobe |
| ld_idx | input | 4 | Operand register index, 0 to 9 |
| ld_data | input | 256 | Operand value to write |
| done | output | 1 | One-cycle completion pulse |
| total | output | 256 | Operand register 0, the accumulated sum |

## Verification
Two pairs of functions can land in the same cycle. The first is the final write-back and an operand load. The bench drives a load of index 0 with a junk value so that it is sampled exactly at the 125th edge. The total must still be the true sum, because the write-back has to win and the load must be dropped. The second pair is the done pulse and a fresh start. The bench raises start during the done cycle and expects a second done exactly 125 edges later, carrying the same total.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } wsr_state_e;
endpackage

// File: rtl/wsr_pipe_add.sv
module wsr_pipe_add #(
    parameter int W   = 256,
    parameter int LAT = 22
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W-1:0] stg_q [LAT];

    always_ff @(posedge clk) begin
        if (rst) stg_q[0] <= '0;
        else     stg_q[0] <= a + b;
    end

    for (genvar s = 1; s < LAT; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg_q[s] <= '0;
            else     stg_q[s] <= stg_q[s-1];
        end
    end

    assign y = stg_q[LAT-1];
endmodule

// File: rtl/wsr_ctrl.sv
module wsr_ctrl
    import wsr_pkg::*;
#(
    parameter int WAIT_CYC = 25,
    parameter int ROUNDS   = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic wb,
    output logic done
);
    localparam int CW = $clog2(WAIT_CYC);
    localparam int RW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

    wsr_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic [RW-1:0] rnd_q;
    logic          tick_end, last_wb;

    assign tick_end = (st_q == S_RUN) && (cnt_q == CW'(WAIT_CYC - 1));
    assign last_wb  = tick_end && (rnd_q == RW'(ROUNDS - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (start)   st_d = S_RUN;
            S_RUN:  if (last_wb) st_d = S_IDLE;
            default:             st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= S_IDLE;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rnd_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= last_wb;
            if (st_q == S_IDLE) begin
                cnt_q <= '0;
                rnd_q <= '0;
            end else if (tick_end) begin
                cnt_q <= '0;
                rnd_q <= rnd_q + RW'(1);
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign busy = (st_q == S_RUN);
    assign wb   = tick_end;

    // R5
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    p_run_needs_start_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R4
    p_done_ends_run_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $fell(busy));

    // R7
    p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !wb) |=> (busy && cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/wide_sum_reducer.sv
module wide_sum_reducer #(
    parameter int W        = 256,
    parameter int NADD     = 5,
    parameter int LAT      = 22,
    parameter int WAIT_CYC = 25,
    parameter int ROUNDS   = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         ld_en,
    input  logic [3:0]   ld_idx,
    input  logic [255:0] ld_data,
    output logic         done,
    output logic [255:0] total
);
    localparam int NOPS = 2 * NADD;

    logic [NOPS-1:0][W-1:0] opr_q;
    logic [NADD-1:0][W-1:0] psum;
    logic                   busy, wb, ld_ok;

    wsr_ctrl #(.WAIT_CYC(WAIT_CYC), .ROUNDS(ROUNDS)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .busy(busy), .wb(wb), .done(done)
    );

    for (genvar k = 0; k < NADD; k++) begin : g_add
        wsr_pipe_add #(.W(W), .LAT(LAT)) u_add (
            .clk(clk), .rst(rst),
            .a(opr_q[2*k]), .b(opr_q[2*k+1]),
            .y(psum[k])
        );
    end

    assign ld_ok = ld_en && !busy && (32'(ld_idx) < NOPS);

    for (genvar i = 0; i < NOPS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                opr_q[i] <= '0;
            else if (wb)
                opr_q[i] <= (i < NADD) ? psum[i % NADD] : '0;
            else if (ld_ok && 32'(ld_idx) == i)
                opr_q[i] <= W'(ld_data);
        end
    end

    assign total = 256'(opr_q[0]);

    // R3
    p_load_blocked_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !wb) |=> $stable(opr_q));

    // R8
    p_total_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(ld_en && ld_idx == 4'd0)) |=> $stable(total));
endmodule

// File: tb/wide_sum_reducer_tb.sv
module wide_sum_reducer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_EDGES  = 125;

    logic         clk = 1'b0;
    logic         rst, start, ld_en, done;
    logic [3:0]   ld_idx;
    logic [255:0] ld_data, total;

    int total_chk = 0;
    int bad = 0;

    wide_sum_reducer u_dut (
        .clk(clk), .rst(rst), .start(start), .ld_en(ld_en),
        .ld_idx(ld_idx), .ld_data(ld_data), .done(done), .total(total)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        total_chk++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [255:0] v);
        ld_en = 1'b1; ld_idx = 4'(idx); ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Pulses start, runs to done, returns edges after accepting edge.
    // poke_at: loop count at which a poke is driven (0 = none).
    task automatic go(output int edges, input int poke_at, input bit p_load, input bit p_start);
        int n;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 400) begin
            if (n == poke_at) begin
                if (p_load) begin ld_en = 1'b1; ld_idx = 4'd0; ld_data = '1; end
                if (p_start) start = 1'b1;
            end
            @(negedge clk);
            n++;
            ld_en = 1'b0;
            start = 1'b0;
        end
        edges = n - 1;
    endtask

    task automatic load_ten(input logic [255:0] base, input logic [255:0] step, output logic [255:0] exp);
        exp = '0;
        for (int i = 0; i < 10; i++) begin
            load(i, base + 256'(i) * step);
            exp = exp + base + 256'(i) * step;
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; start = 1'b0; ld_en = 1'b0; ld_idx = '0; ld_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(done == 1'b0, "R1 done after reset", 256'(done), 0);
        chk(total == '0, "R1 total after reset", total, 0);
    endtask

    task automatic t_basic;
        logic [255:0] exp;
        int e;
        load_ten(256'd1, 256'd1, exp);
        chk(total == 256'd1, "R2 reg0 loaded", total, 1);
        go(e, 0, 0, 0);
        chk(e == RUN_EDGES, "R4 done timing", 256'(e), 256'(RUN_EDGES));
        chk(total == exp, "R6 small sum", total, exp);
        @(negedge clk);
        chk(done == 1'b0, "R5 done one cycle", 256'(done), 0);
    endtask

    task automatic t_wrap;
        logic [255:0] exp;
        int e;
        load_ten('1, 256'd0, exp);
        go(e, 0, 0, 0);
        chk(total == exp && exp == ~256'd9, "R6 carry dropped", total, ~256'd9);
        @(negedge clk);
    endtask

    task automatic t_bad_index;
        logic [255:0] exp;
        int e;
        load_ten(256'h1234_0000_0000_0000_0000_0000_0000_0001, 256'd7, exp);
        load(12, 256'hdead);
        load(15, 256'hbeef);
        go(e, 0, 0, 0);
        chk(total == exp, "R2 index 10..15 ignored", total, exp);
        @(negedge clk);
    endtask

    task automatic t_busy_load;
        logic [255:0] exp;
        int e;
        load_ten(256'd100, 256'd3, exp);
        go(e, 40, 1, 0);
        chk(total == exp, "R3 mid-run load ignored", total, exp);
        @(negedge clk);
        load_ten(256'd5, 256'd11, exp);
        go(e, RUN_EDGES, 1, 0);
        chk(total == exp, "R3 load at final write-back ignored", total, exp);
        @(negedge clk);
    endtask

    task automatic t_busy_start;
        logic [255:0] exp;
        int e;
        load_ten(256'd9, 256'd9, exp);
        go(e, 50, 0, 1);
        chk(e == RUN_EDGES, "R7 start while running ignored", 256'(e), 256'(RUN_EDGES));
        chk(total == exp, "R7 sum intact", total, exp);
        @(negedge clk);
    endtask

    task automatic t_hold_and_rerun;
        logic [255:0] keep;
        int e, n;
        keep = total;
        repeat (20) @(negedge clk);
        chk(total == keep, "R8 total holds while idle", total, keep);
        go(e, 0, 0, 0);
        chk(total == keep, "R8 rerun reproduces total", total, keep);
        // done is high now: raise start in this very cycle
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 400) begin @(negedge clk); n++; end
        chk(n - 1 == RUN_EDGES, "R9 start in done cycle accepted", 256'(n - 1), 256'(RUN_EDGES));
        chk(total == keep, "R9 total after second run", total, keep);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total_chk++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total_chk, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_bad_index();
        t_busy_load();
        t_busy_start();
        t_hold_and_rerun();
        $display("test done: total=%0d bad=%0d", total_chk, bad);
        $finish;
    end
endmodule